// File: doc/BRIEF.md
# Microcode Sequencer and Decoder

This block steps through a fixed microprogram held in an internal ROM and turns each 16-bit microword into control signals for a 4-bit datapath. A 10-bit micro program counter selects the current word. The top three bits of the word set its class. The decoder then exposes the fields that class carries: source, destination and post-increment code for register transfers, or operation, destination, post-increment code and a flag-write enable for ALU transfers. The PC-load, call/return and table-jump-end classes each raise their own one-step strobe.

Jump microwords redirect the micro program counter. A jump is either taken always, or taken only when a chosen datapath flag (zero or carry) has a chosen level. The sequencer runs at twice the CPU cycle rate, so it also presents a phase output that marks the fetch half of each CPU cycle. A halt microword freezes sequencing until the next reset, and one of its bits can also request that the peripheral oscillator stop. The datapath, the ALU and memory sit outside the block.

Top module: `useq_top`

## Requirements
- R1: `op_class` equals bits 15:13 of the current microword (0 no-op, 1 transfer, 2 ALU transfer, 3 PC load, 4 jump, 5 call/return, 6 table-jump end, 7 halt). The strobes `xfer_strobe`, `alu_strobe`, `pcload_strobe`, `callret_strobe` and `tjmp_strobe` are high exactly for classes 1, 2, 3, 5 and 6, so at most one is high at a time.
- R2: For a transfer, `src_sel` = bits 12:8, `dst_sel` = bits 7:3 and `inc_code` = bits 2:0. These three outputs are zero for every class other than transfer and ALU transfer.
- R3: For an ALU transfer, `src_sel` is the fixed ALU source code 31, `alu_op` = bits 11:8, `flag_we` = bit 12, `dst_sel` = bits 7:3 and `inc_code` = bits 2:0. `alu_op` and `flag_we` are zero for every other class.
- R4: A jump with bit 12 set loads bits 9:0 into the micro program counter when the flag named by bit 11 (0 zero, 1 carry) equals bit 10. Otherwise the counter advances by one.
- R5: A jump with bit 12 clear is always taken, whatever the flags and bits 11:10.
- R6: Every non-jump, non-halt microword advances the micro program counter by one. The counter wraps from 1023 to 0.
- R7: A halt microword sets `halted` on the next step and latches bit 0 into `osc_stop`. Both then hold, and the counter stays frozen, until reset.
- R8: While the synchronised reset is active, `upc` is 0, `halted` and `osc_stop` are 0 and `fetch_step` is 1. Sequencing starts on the third rising edge after `rst_n` rises.
- R9: `fetch_step` alternates on every step while not halted, starting high, and stops changing once halted.
- R10: A no-op raises no strobe, leaves all fields zero and only advances the counter.
- R11: `callret_arg` equals bit 0 of a call/return microword and is 0 for every other class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Microstep clock (twice the CPU cycle rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_zero | input | 1 | Datapath zero flag |
| flag_carry | input | 1 | Datapath carry flag |
| upc | output | 10 | Current micro program counter |
| op_class | output | 3 | Class of the current microword |
| src_sel | output | 5 | Transfer source select |
| dst_sel | output | 5 | Transfer destination select |
| inc_code | output | 3 | Post-increment code |
| alu_op | output | 4 | ALU operation |
| flag_we | output | 1 | Flag write enable for ALU transfers |
| xfer_strobe | output | 1 | Register transfer this step |
| alu_strobe | output | 1 | ALU transfer this step |
| pcload_strobe | output | 1 | PC load this step |
| callret_strobe | output | 1 | Call/return special this step |
| callret_arg | output | 1 | Option bit of the call/return word |
| tjmp_strobe | output | 1 | Table-jump end this step |
| halted | output | 1 | Sequencer stopped |
| osc_stop | output | 1 | Peripheral oscillator stop request |
| fetch_step | output | 1 | High on the fetch half of a CPU cycle |

## Verification
The bench drives pseudo-random flags so that every conditional jump is seen both taken and not taken, for both flags and both required levels. A polarity inversion or a swapped flag select would send the micro program counter to the wrong address on the next step. An unconditional jump whose flag and level bits are set checks that a design which read those bits would sometimes fall through. A jump to address 1023 followed by a no-op checks that the counter wraps to 0. The halt word with its oscillator bit set is followed for many steps, so a halt that leaked, a counter that kept moving or a phase that kept toggling would show up. A second reset then checks that halt is released and that sequencing resumes only after the two-stage reset release.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int UPC_W  = 10;
  localparam int WORD_W = 16;
  localparam int SEL_W  = 5;
  localparam int INC_W  = 3;
  localparam int OP_W   = 4;

  typedef enum logic [2:0] {
    CLS_NOP     = 3'd0,
    CLS_XFER    = 3'd1,
    CLS_ALU     = 3'd2,
    CLS_PCLD    = 3'd3,
    CLS_JMP     = 3'd4,
    CLS_CALLRET = 3'd5,
    CLS_TJMP    = 3'd6,
    CLS_HALT    = 3'd7
  } ucls_e;

  typedef struct packed {
    ucls_e              cls;
    logic [SEL_W-1:0]   src;
    logic [SEL_W-1:0]   dst;
    logic [INC_W-1:0]   inc;
    logic [OP_W-1:0]    alu_op;
    logic               flag_we;
    logic               jmp_cond;
    logic               jmp_carry;
    logic               jmp_level;
    logic [UPC_W-1:0]   jmp_tgt;
    logic               opt_bit;
  } udec_t;
endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int AW = UPC_W,
  parameter int DW = WORD_W
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] word
);
  always_comb begin
    case (addr)
      AW'(1):    word = DW'(16'h232A);
      AW'(2):    word = DW'(16'h5A39);
      AW'(3):    word = DW'(16'h4310);
      AW'(4):    word = DW'(16'h6000);
      AW'(5):    word = DW'(16'h9408);
      AW'(6):    word = DW'(16'h2111);
      AW'(8):    word = DW'(16'h980C);
      AW'(9):    word = DW'(16'hA001);
      AW'(10):   word = DW'(16'h800E);
      AW'(12):   word = DW'(16'h9C14);
      AW'(13):   word = DW'(16'hC000);
      AW'(14):   word = DW'(16'h9002);
      AW'(15):   word = DW'(16'h8C1E);
      AW'(20):   word = DW'(16'hA800);
      AW'(21):   word = DW'(16'h83FF);
      AW'(30):   word = DW'(16'hE001);
      default:   word = '0;
    endcase
  end
endmodule

// File: rtl/useq_decode.sv
module useq_decode
  import useq_pkg::*;
#(
  parameter logic [SEL_W-1:0] ALU_SRC = 5'd31
) (
  input  logic [WORD_W-1:0] word,
  output udec_t             dec
);
  ucls_e cls;
  assign cls = ucls_e'(word[15:13]);

  always_comb begin
    dec     = '0;
    dec.cls = cls;
    case (cls)
      CLS_XFER: begin
        dec.src = word[12:8];
        dec.dst = word[7:3];
        dec.inc = word[2:0];
      end
      CLS_ALU: begin
        dec.src     = ALU_SRC;
        dec.flag_we = word[12];
        dec.alu_op  = word[11:8];
        dec.dst     = word[7:3];
        dec.inc     = word[2:0];
      end
      CLS_JMP: begin
        dec.jmp_cond  = word[12];
        dec.jmp_carry = word[11];
        dec.jmp_level = word[10];
        dec.jmp_tgt   = word[UPC_W-1:0];
      end
      CLS_CALLRET, CLS_HALT: begin
        dec.opt_bit = word[0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/useq_seq.sv
module useq_seq
  import useq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  udec_t            dec,
  input  logic             flag_zero,
  input  logic             flag_carry,
  output logic [UPC_W-1:0] upc,
  output logic             halted,
  output logic             osc_stop,
  output logic             fetch_step
);
  logic [UPC_W-1:0] upc_q, upc_d;
  logic             halt_q, halt_d;
  logic             osc_q, osc_d;
  logic             ph_q, ph_d;
  logic             step_en;
  logic             sel_flag;
  logic             take;

  assign step_en  = ~halt_q;
  assign sel_flag = dec.jmp_carry ? flag_carry : flag_zero;
  assign take     = (dec.cls == CLS_JMP) &&
                    (~dec.jmp_cond || (sel_flag == dec.jmp_level));

  always_comb begin
    upc_d  = upc_q;
    halt_d = halt_q;
    osc_d  = osc_q;
    ph_d   = ~ph_q;
    if (dec.cls == CLS_HALT) begin
      halt_d = 1'b1;
      osc_d  = dec.opt_bit;
    end else if (take) begin
      upc_d = dec.jmp_tgt;
    end else begin
      upc_d = upc_q + UPC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upc_q  <= '0;
      halt_q <= 1'b0;
      osc_q  <= 1'b0;
      ph_q   <= 1'b0;
    end else if (step_en) begin
      upc_q  <= upc_d;
      halt_q <= halt_d;
      osc_q  <= osc_d;
      ph_q   <= ph_d;
    end
  end

  assign upc        = upc_q;
  assign halted     = halt_q;
  assign osc_stop   = osc_q;
  assign fetch_step = ~ph_q;

  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(upc) && $stable(osc_stop)));
  assert_phase_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |=> (fetch_step != $past(fetch_step)));
  assert_phase_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(fetch_step));
  assert_seq_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && dec.cls != CLS_JMP && dec.cls != CLS_HALT)
      |=> (upc == $past(upc) + UPC_W'(1)));
  assert_uncond_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && dec.cls == CLS_JMP && !dec.jmp_cond) |=> (upc == $past(dec.jmp_tgt)));
  assert_halt_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && dec.cls == CLS_HALT) |=> (halted && osc_stop == $past(dec.opt_bit)));
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flag_zero,
  input  logic        flag_carry,
  output logic [9:0]  upc,
  output logic [2:0]  op_class,
  output logic [4:0]  src_sel,
  output logic [4:0]  dst_sel,
  output logic [2:0]  inc_code,
  output logic [3:0]  alu_op,
  output logic        flag_we,
  output logic        xfer_strobe,
  output logic        alu_strobe,
  output logic        pcload_strobe,
  output logic        callret_strobe,
  output logic        callret_arg,
  output logic        tjmp_strobe,
  output logic        halted,
  output logic        osc_stop,
  output logic        fetch_step
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic [WORD_W-1:0] word;
  udec_t             dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  useq_rom #(.AW(UPC_W), .DW(WORD_W)) u_rom (
    .addr (upc),
    .word (word)
  );

  useq_decode #(.ALU_SRC(5'd31)) u_dec (
    .word (word),
    .dec  (dec)
  );

  useq_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .dec        (dec),
    .flag_zero  (flag_zero),
    .flag_carry (flag_carry),
    .upc        (upc),
    .halted     (halted),
    .osc_stop   (osc_stop),
    .fetch_step (fetch_step)
  );

  assign op_class       = dec.cls;
  assign src_sel        = dec.src;
  assign dst_sel        = dec.dst;
  assign inc_code       = dec.inc;
  assign alu_op         = dec.alu_op;
  assign flag_we        = dec.flag_we;
  assign xfer_strobe    = (dec.cls == CLS_XFER);
  assign alu_strobe     = (dec.cls == CLS_ALU);
  assign pcload_strobe  = (dec.cls == CLS_PCLD);
  assign callret_strobe = (dec.cls == CLS_CALLRET);
  assign tjmp_strobe    = (dec.cls == CLS_TJMP);
  assign callret_arg    = callret_strobe & dec.opt_bit;

  assert_strobe_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n_int)
    $onehot0({xfer_strobe, alu_strobe, pcload_strobe, callret_strobe, tjmp_strobe}));
  assert_flagwe_alu_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    flag_we |-> alu_strobe);
  assert_nop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    (op_class == 3'd0) |-> (src_sel == '0 && dst_sel == '0 && inc_code == '0 && !flag_we));
  assert_reset_state_R8: assert property (@(posedge clk)
    !rst_n_int |-> (upc == '0 && !halted && !osc_stop && fetch_step));
endmodule

// File: tb/test_useq_top.sv
module test_useq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flag_zero = 1'b0;
  logic       flag_carry = 1'b0;
  logic [9:0] upc;
  logic [2:0] op_class;
  logic [4:0] src_sel, dst_sel;
  logic [2:0] inc_code;
  logic [3:0] alu_op;
  logic       flag_we, xfer_strobe, alu_strobe, pcload_strobe;
  logic       callret_strobe, callret_arg, tjmp_strobe;
  logic       halted, osc_stop, fetch_step;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  // reference model state
  int m_pc;
  bit m_halt, m_osc, m_ph;
  int hold;
  bit rst_req;
  logic [7:0] lfsr = 8'hA5;
  bit force_exit;

  always #4 clk = ~clk;

  useq_top i_useq_top (
    .clk(clk), .rst_n(rst_n), .flag_zero(flag_zero), .flag_carry(flag_carry),
    .upc(upc), .op_class(op_class), .src_sel(src_sel), .dst_sel(dst_sel),
    .inc_code(inc_code), .alu_op(alu_op), .flag_we(flag_we),
    .xfer_strobe(xfer_strobe), .alu_strobe(alu_strobe),
    .pcload_strobe(pcload_strobe), .callret_strobe(callret_strobe),
    .callret_arg(callret_arg), .tjmp_strobe(tjmp_strobe),
    .halted(halted), .osc_stop(osc_stop), .fetch_step(fetch_step)
  );

  function automatic logic [15:0] prog(input int a);
    case (a)
      1: return 16'h232A;  2: return 16'h5A39;  3: return 16'h4310;
      4: return 16'h6000;  5: return 16'h9408;  6: return 16'h2111;
      8: return 16'h980C;  9: return 16'hA001;  10: return 16'h800E;
      12: return 16'h9C14; 13: return 16'hC000; 14: return 16'h9002;
      15: return 16'h8C1E; 20: return 16'hA800; 21: return 16'h83FF;
      30: return 16'hE001;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at upc %0d: actual %0d expected %0d", req, what, m_pc, act, exp);
    end
  endtask

  task automatic step();
    logic [15:0] w;
    int c, e_src, e_dst, e_inc, e_alu, e_fwe, e_arg;
    int e_stb, a_stb;
    bit fz, fc, sel;
    @(negedge clk);
    rst_n = rst_req;
    if (!rst_req) begin
      m_pc = 0; m_halt = 0; m_osc = 0; m_ph = 0; hold = 2;
    end
    #1;
    w = prog(m_pc);
    c = int'(w[15:13]);
    e_src = (c == 1) ? int'(w[12:8]) : (c == 2) ? 31 : 0;
    e_dst = (c == 1 || c == 2) ? int'(w[7:3]) : 0;
    e_inc = (c == 1 || c == 2) ? int'(w[2:0]) : 0;
    e_alu = (c == 2) ? int'(w[11:8]) : 0;
    e_fwe = (c == 2) ? int'(w[12]) : 0;
    e_arg = (c == 5) ? int'(w[0]) : 0;
    e_stb = {27'd0, c == 1, c == 2, c == 3, c == 5, c == 6};
    a_stb = {27'd0, xfer_strobe, alu_strobe, pcload_strobe, callret_strobe, tjmp_strobe};

    if (!rst_req || hold > 0) begin
      chk(upc == 0 && !halted && !osc_stop && fetch_step, "R8", "reset state upc",
          int'(upc), 0);
    end else begin
      chk(int'(upc) == m_pc, (c == 0) ? "R10" : "R6", "upc trajectory", int'(upc), m_pc);
    end
    chk(int'(op_class) == c, "R1", "op_class", int'(op_class), c);
    chk(a_stb == e_stb, (c == 0) ? "R10" : "R1", "strobes", a_stb, e_stb);
    chk(int'(src_sel) == e_src, (c == 2) ? "R3" : "R2", "src_sel", int'(src_sel), e_src);
    chk(int'(dst_sel) == e_dst, "R2", "dst_sel", int'(dst_sel), e_dst);
    chk(int'(inc_code) == e_inc, "R2", "inc_code", int'(inc_code), e_inc);
    chk(int'(alu_op) == e_alu, "R3", "alu_op", int'(alu_op), e_alu);
    chk(int'(flag_we) == e_fwe, "R3", "flag_we", int'(flag_we), e_fwe);
    chk(int'(callret_arg) == e_arg, "R11", "callret_arg", int'(callret_arg), e_arg);
    chk(halted == m_halt, "R7", "halted", int'(halted), int'(m_halt));
    chk(osc_stop == m_osc, "R7", "osc_stop", int'(osc_stop), int'(m_osc));
    chk(fetch_step == !m_ph, "R9", "fetch_step", int'(fetch_step), int'(!m_ph));

    // new flags for the coming edge
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (force_exit) begin fz = 1'b1; fc = 1'b0; end
    else begin fz = lfsr[0]; fc = lfsr[3]; end
    flag_zero  = fz;
    flag_carry = fc;

    // advance the model across the next rising edge
    if (rst_req) begin
      if (hold > 0) hold--;
      else if (!m_halt) begin
        m_ph = !m_ph;
        if (c == 7) begin
          m_halt = 1; m_osc = w[0];
        end else if (c == 4) begin
          sel = w[11] ? fc : fz;
          if (!w[12] || sel == w[10]) m_pc = int'(w[9:0]);
          else m_pc = (m_pc + 1) % 1024;
        end else begin
          m_pc = (m_pc + 1) % 1024;
        end
      end
    end
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_tests++; n_fail++;
        $display("FAIL R6 watchdog: actual %0d cycles expected under %0d", cycles, 20000);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    force_exit = 0;
    rst_req = 0;
    for (int i = 0; i < 3; i++) step();          // R8 reset held
    rst_req = 1;
    for (int i = 0; i < 600; i++) step();        // random flags: R4 R5 both polarities
    force_exit = 1;
    for (int i = 0; i < 400 && !m_halt; i++) step();
    chk(m_halt, "R7", "halt reached by program", int'(m_halt), 1);
    for (int i = 0; i < 20; i++) step();         // R7 R9 frozen while halted
    rst_req = 0;
    for (int i = 0; i < 2; i++) step();          // R8 second reset releases halt
    rst_req = 1;
    force_exit = 0;
    for (int i = 0; i < 40; i++) step();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule